// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller services a processor read miss by refilling a four-word cache line from a memory port that returns one word per cycle. When a miss is accepted, it issues one burst request to memory. In critical-word-first mode the burst starts at the missed word and wraps around the line. In early-restart mode the burst starts at the line base. In both modes the processor's stall ends in the cycle its word arrives: that word goes from the memory data bus directly to the processor response, and the rest of the line continues to fill in the background.

While the fill is running, the processor may ask for other words of the same line. A word that is already in the fill buffer is returned at once. A word that is still missing stalls the processor until the memory delivers it. A request to any other line is held off until the whole line has been handed to the data array through the line-write port. The line-write pulse is the only point at which the line becomes usable. Tag lookup and victim choice happen outside this block.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, cpu_stall, cpu_rvalid, mem_req and lw_en are all low.
- R2: With crit_first=1, a request seen while idle is taken as a miss. In the next cycle mem_req pulses for exactly one cycle, and mem_addr equals the requested word address, keeping its low two offset bits.
- R3: With crit_first=0, the burst address carries the requested line with offset bits [1:0] forced to zero.
- R4: The requested word is returned with cpu_rvalid high and cpu_rdata equal to mem_rdata in the same cycle that mem_rvalid delivers it.
- R5: cpu_stall is high in every cycle from the accepted miss until its word is delivered. cpu_rvalid is only ever high while cpu_req is high.
- R6: Memory returns four words in wrapping order from the burst start offset. The k-th word received is stored at offset (start+k) mod 4, and lw_data holds word i in bits [32*i+31:32*i].
- R7: A request to the line being filled, for a word that has already arrived, is answered from the fill buffer in the same cycle without a stall.
- R8: A request to the line being filled, for a word not yet received, stalls until that word arrives and is then forwarded from memory.
- R9: lw_en pulses once, one cycle after the fourth word is received. It carries lw_addr equal to address bits [15:2] and the complete line, and it is never high earlier.
- R10: A request to a different line during a fill stalls and starts no memory request until the line write has happened. After that it is accepted as a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_first | input | 1 | 1: burst starts at the missed word; 0: burst starts at the line base |
| cpu_req | input | 1 | Processor read request, held until answered |
| cpu_addr | input | 16 | Processor word address |
| cpu_stall | output | 1 | Request pending and not answered this cycle |
| cpu_rvalid | output | 1 | Request answered this cycle |
| cpu_rdata | output | 32 | Returned word |
| mem_req | output | 1 | One-cycle burst request |
| mem_addr | output | 16 | Word address of the first burst word |
| mem_rvalid | input | 1 | Memory delivers a word this cycle |
| mem_rdata | input | 32 | Delivered word |
| lw_en | output | 1 | Write completed line into the data array |
| lw_addr | output | 14 | Line address of the write |
| lw_data | output | 128 | Completed line, word 0 in the low bits |

## Verification
A memory word can arrive in the same cycle that the processor reads the fill buffer. The read is either for that same word, which must bypass from the memory bus, or for an earlier word, which must come from the buffer while the new word is being stored. The bench provokes both cases by holding back-to-back requests to one line while gap-free and gapped bursts stream in. It judges them by the data popped from the scoreboard, by the stall-cycle count, and by whether mem_rvalid was high in the answering cycle.

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    crit_first,
  input  logic                    cpu_req,
  input  logic [ADDR_W-1:0]       cpu_addr,
  output logic                    cpu_stall,
  output logic                    cpu_rvalid,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    lw_en,
  output logic [ADDR_W-$clog2(WORDS)-1:0] lw_addr,
  output logic [WORDS*DATA_W-1:0] lw_data
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DONE} st_t;

  st_t               st_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  nxt_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [WORDS-1:0]  have_q;
  logic [DATA_W-1:0] buf_q [WORDS];
  logic              mem_req_q;
  logic [ADDR_W-1:0] mem_addr_q;

  logic [LINE_W-1:0] req_line;
  logic [OFF_W-1:0]  req_off;
  logic              same, fwd, hit, start, take;

  assign req_line   = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off    = cpu_addr[OFF_W-1:0];
  assign same       = (st_q != S_IDLE) && (req_line == line_q);
  assign take       = (st_q == S_FILL) && mem_rvalid;
  assign fwd        = same && take && (nxt_q == req_off);
  assign hit        = same && have_q[req_off];
  assign start      = (st_q == S_IDLE) && cpu_req;

  assign cpu_rvalid = cpu_req && (hit || fwd);
  assign cpu_stall  = cpu_req && !cpu_rvalid;
  assign cpu_rdata  = hit ? buf_q[req_off] : mem_rdata;
  assign mem_req    = mem_req_q;
  assign mem_addr   = mem_addr_q;
  assign lw_en      = (st_q == S_DONE);
  assign lw_addr    = line_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_pack
    assign lw_data[i*DATA_W +: DATA_W] = buf_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      line_q     <= '0;
      nxt_q      <= '0;
      cnt_q      <= '0;
      have_q     <= '0;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
    end else begin
      mem_req_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          line_q     <= req_line;
          nxt_q      <= crit_first ? req_off : '0;
          cnt_q      <= '0;
          have_q     <= '0;
          mem_req_q  <= 1'b1;
          mem_addr_q <= {req_line, crit_first ? req_off : {OFF_W{1'b0}}};
          st_q       <= S_FILL;
        end
        S_FILL: if (take) begin
          have_q[nxt_q] <= 1'b1;
          nxt_q         <= nxt_q + 1'b1;
          cnt_q         <= cnt_q + 1'b1;
          if (cnt_q == OFF_W'(WORDS - 1)) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[nxt_q] <= mem_rdata;
  end
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              crit_first,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_stall,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              lw_en
);
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r2_cwf_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(crit_first) |-> mem_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0]));
  a_r3_er_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !$past(crit_first) |-> mem_addr[OFF_W-1:0] == '0);
  a_r10_req_from_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(cpu_req && cpu_stall));
  a_r9_lw_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    lw_en |-> $past(mem_rvalid));
  a_r9_lw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lw_en |=> !lw_en);
  a_r10_no_req_at_lw: assert property (@(posedge clk) disable iff (!rst_n)
    lw_en |-> !mem_req);
  a_r5_rvalid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> cpu_req);
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .crit_first(crit_first), .cpu_req(cpu_req),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .lw_en(lw_en)
);

// File: tb/test_cwf_line_fill.sv
module test_cwf_line_fill;
  logic         clk = 1'b0, rst_n = 1'b0, crit_first = 1'b1, cpu_req = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic         cpu_stall, cpu_rvalid, mem_req, lw_en;
  logic [31:0]  cpu_rdata;
  logic [15:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic [13:0]  lw_addr;
  logic [127:0] lw_data;

  cwf_line_fill i_cwf_line_fill (
    .clk(clk), .rst_n(rst_n), .crit_first(crit_first), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .lw_en(lw_en),
    .lw_addr(lw_addr), .lw_data(lw_data)
  );

  always #2 clk = ~clk;

  int          n_tests = 0, n_fail = 0, gap = 0, lw_seen = 0;
  logic [31:0] exp_q [$];
  logic [15:0] exp_maddr = '0;
  bit          filling = 1'b0;

  function automatic logic [31:0] wd(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 response with nothing pending", cpu_rdata, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cpu_rdata == e, "R4/R7 returned word", cpu_rdata, e);
      end
    end
    if (rst_n && lw_en) lw_seen++;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        logic [15:0]  a;
        logic [127:0] line;
        chk(!filling, "R10 burst only after line write", filling, 0);
        chk(mem_addr == exp_maddr, "R2/R3 burst start address", mem_addr, exp_maddr);
        filling = 1'b1;
        a = mem_addr;
        for (int k = 0; k < 4; k++) begin
          repeat (gap) begin @(posedge clk); #1 mem_rvalid = 1'b0; end
          @(posedge clk); #1;
          mem_rvalid = 1'b1;
          mem_rdata  = wd({a[15:2], 2'(a[1:0] + 2'(k))});
        end
        @(posedge clk); #1 mem_rvalid = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) line[i*32 +: 32] = wd({a[15:2], 2'(i)});
        chk(lw_en == 1'b1, "R9 line write one cycle after last word", lw_en, 1);
        chk(lw_addr == a[15:2], "R9 line write address", lw_addr, a[15:2]);
        chk(lw_data == line, "R6 line contents in offset order", lw_data, line);
        filling = 1'b0;
      end
    end
  end

  task automatic cpu_read(input logic [15:0] a, input bit hit_now, input string tag);
    int stalls = 0;
    bit fwd;
    @(posedge clk); #1;
    cpu_req  = 1'b1;
    cpu_addr = a;
    exp_q.push_back(wd(a));
    forever begin
      @(negedge clk);
      if (cpu_rvalid) break;
      if (!cpu_stall) chk(1'b0, {tag, " stall low while unanswered"}, cpu_stall, 1);
      stalls++;
    end
    fwd = mem_rvalid;
    if (hit_now) chk(stalls == 0, {tag, " answered from buffer without stall"}, stalls, 0);
    else chk(stalls > 0 && fwd, {tag, " released on arrival of its word"}, {stalls, 1'b0, fwd}, 1);
  endtask

  task automatic cpu_done();
    @(posedge clk); #1 cpu_req = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cpu_stall && !cpu_rvalid && !mem_req && !lw_en, "R1 quiet outputs in reset",
        {cpu_stall, cpu_rvalid, mem_req, lw_en}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_stall && !cpu_rvalid && !mem_req && !lw_en, "R1 quiet outputs after reset",
        {cpu_stall, cpu_rvalid, mem_req, lw_en}, 0);

    crit_first = 1'b1; gap = 2; exp_maddr = 16'h0102;
    cpu_read(16'h0102, 1'b0, "R2 R4 R5 critical word");
    cpu_read(16'h0101, 1'b0, "R8 word still missing");
    cpu_read(16'h0103, 1'b1, "R7 word already buffered");
    cpu_done();

    crit_first = 1'b0; gap = 0; exp_maddr = 16'h0230;
    cpu_read(16'h0232, 1'b0, "R3 R4 early restart");
    cpu_read(16'h0230, 1'b1, "R7 early-restart buffered word");
    cpu_done();

    crit_first = 1'b1; gap = 3; exp_maddr = 16'h0341;
    cpu_read(16'h0341, 1'b0, "R2 R5 slow burst");
    exp_maddr = 16'h0452;
    cpu_read(16'h0452, 1'b0, "R10 other line during fill");
    cpu_done();

    gap = 0; exp_maddr = 16'h05F3;
    cpu_read(16'h05F3, 1'b0, "R6 wrap from last offset");
    cpu_read(16'h05F2, 1'b0, "R8 wrapped word");
    cpu_done();

    chk(lw_seen == 5, "R9 one line write per fill", lw_seen, 5);
    chk(exp_q.size() == 0, "R4 all reads answered", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule